// File: doc/BRIEF.md
# Prioritised Interrupt Controller Bank

This block gathers up to 32 interrupt lines into one bank and presents two requests to a processor: a normal request and a fast request. Each line has its own configuration word. The word routes the line to one of the two requests, gives it a 5-bit urgency value and chooses level or rising-edge sensing. A mask word can gate any line. A pending word shows which lines are asserted or latched, whether or not they are masked.

For each of the two requests the bank picks one winner among the unmasked pending lines routed to it. A smaller urgency value wins. Between equal values, the lower line number wins. The winner's number is frozen into a readable register while the request is high. Software reads the fast-request number first and the normal-request number after it. It then writes a control word to acknowledge one request or both. One cycle after an acknowledge, the bank makes a fresh decision for that request. A parameter disables fast routing, so that the same block can serve as a secondary bank in a cascade.

Register map (byte offsets): pending at 0x00, mask at 0x04, normal winner number at 0x10, fast winner number at 0x14, control at 0x18. The configuration words follow from 0x20 in steps of four.

Top module: `intc_bank`

## Requirements
- R1: After reset the mask reads all ones, both requests are low, both winner-number registers read 0 and every configuration word reads 0.
- R2: The configuration word of line n sits at offset 0x20 + 4·n. Bit 0 routes to fast (1) or normal (0), bit 1 selects level (1) or rising edge (0), and bits 6:2 hold the urgency. Bits 31:7 read as 0.
- R3: With FIQ_EN = 0, bit 0 of every configuration word reads 0 and the fast request never rises. A line written with bit 0 set is served on the normal request.
- R4: A 1 in mask bit n keeps line n from either request. The pending word at 0x00 still shows the line.
- R5: In level mode, pending bit n follows the input line.
- R6: In edge mode, a rising edge sets pending bit n and the bit stays set after the input falls. It is cleared by writing 0 to that bit of the pending word, or by acknowledging the request whose frozen winner is line n.
- R7: Among the candidates for one request, the smallest urgency value wins. Equal values go to the lowest line number.
- R8: The normal request is high and 0x10 holds the winning line number while an unmasked pending line is routed to normal. With no request held, 0x10 reads 0.
- R9: The fast request and 0x14 behave in the same way for lines routed to fast. Such lines never take part in the normal decision.
- R10: While a request is high, its number register and the request itself hold even when a better line arrives. Writing control bit 0 acknowledges normal, bit 1 acknowledges fast and 0x3 acknowledges both. A new decision follows on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | NUM_SRC | Interrupt lines, synchronous to clk |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The bench builds two copies with NUM_SRC = 32 and ADDR_W = 8, so every line and every configuration offset up to 0x9C can be reached. One copy is a primary bank with FIQ_EN = 1, where fast routing, the separate fast acknowledge and the fast-first order can all be exercised. The second copy has FIQ_EN = 0 and sees the same stimulus. Reading its configuration words and its two requests shows the forced-normal routing of a secondary bank.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int PRIO_W = 5;

  // byte offsets of the bank registers
  localparam int OFS_PEND = 'h00;
  localparam int OFS_MASK = 'h04;
  localparam int OFS_IRQN = 'h10;
  localparam int OFS_FIQN = 'h14;
  localparam int OFS_CTRL = 'h18;
  localparam int OFS_CFG0 = 'h20;

  // configuration word: prio[6:2], level[1], fast[0]
  typedef struct packed {
    logic [PRIO_W-1:0] prio;
    logic              lvl;
    logic              fast;
  } src_cfg_t;

  function automatic src_cfg_t decode_cfg(input logic [6:0] w, input logic fast_ok);
    src_cfg_t c;
    c.prio = w[6:2];
    c.lvl  = w[1];
    c.fast = w[0] & fast_ok;
    return c;
  endfunction

  function automatic int cfg_offset(input int n);
    return OFS_CFG0 + 4 * n;
  endfunction
endpackage

// File: rtl/intc_cfg_regs.sv
module intc_cfg_regs
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter bit FIQ_EN  = 1'b1,
  parameter int ADDR_W  = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [6:0]                 wdata_i,
  output src_cfg_t [NUM_SRC-1:0]     cfg_o
);
  for (genvar n = 0; n < NUM_SRC; n++) begin : g_cfg
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(cfg_offset(n));
    logic sel;
    assign sel = wr_en_i && (addr_i == MY_ADDR);
    always_ff @(posedge clk) begin
      if (!rst_n)   cfg_o[n] <= '0;
      else if (sel) cfg_o[n] <= decode_cfg(wdata_i, FIQ_EN);
    end
  end
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 32,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_SRC-1:0]     active_i,
  input  src_cfg_t [NUM_SRC-1:0] cfg_i,
  input  logic                   route_fast_i,
  output logic                   found_o,
  output logic [IDX_W-1:0]       idx_o
);
  logic [PRIO_W-1:0] best_prio;

  // strict compare keeps the earlier (lower) line on equal urgency
  always_comb begin
    found_o   = 1'b0;
    idx_o     = '0;
    best_prio = '1;
    for (int n = 0; n < NUM_SRC; n++) begin
      if (active_i[n] && (cfg_i[n].fast == route_fast_i) &&
          (!found_o || (cfg_i[n].prio < best_prio))) begin
        found_o   = 1'b1;
        idx_o     = IDX_W'(n);
        best_prio = cfg_i[n].prio;
      end
    end
  end

  // R7
  winner_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    found_o |-> (active_i[idx_o] && (cfg_i[idx_o].fast == route_fast_i)));
endmodule

// File: rtl/intc_route.sv
module intc_route #(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             found_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             ack_i,
  output logic             req_o,
  output logic [IDX_W-1:0] num_o,
  output logic             ack_hit_o
);
  assign ack_hit_o = ack_i && req_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_o <= 1'b0;
      num_o <= '0;
    end else if (ack_i) begin
      req_o <= 1'b0;
      num_o <= '0;
    end else if (!req_o && found_i) begin
      req_o <= 1'b1;
      num_o <= idx_i;
    end
  end

  // R10
  frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && !ack_i) |=> (req_o && $stable(num_o)));
  // R8
  rise_has_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_o) |-> ($past(found_i) && (num_o == $past(idx_i))));
endmodule

// File: rtl/intc_bank.sv
module intc_bank
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter bit FIQ_EN  = 1'b1,
  parameter int ADDR_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        rdata_o,
  output logic               irq_o,
  output logic               fiq_o
);
  localparam int IDX_W = $clog2(NUM_SRC);

  src_cfg_t [NUM_SRC-1:0] cfg;
  logic [NUM_SRC-1:0] prev_q, edge_q, pend, mask_q, active;
  logic               pend_wr, mask_wr, ctrl_wr;
  logic               irq_found, fiq_found, irq_hit, fiq_hit;
  logic [IDX_W-1:0]   irq_idx, fiq_idx, irq_num, fiq_num;

  assign pend_wr = wr_en_i && (addr_i == ADDR_W'(OFS_PEND));
  assign mask_wr = wr_en_i && (addr_i == ADDR_W'(OFS_MASK));
  assign ctrl_wr = wr_en_i && (addr_i == ADDR_W'(OFS_CTRL));

  intc_cfg_regs #(.NUM_SRC(NUM_SRC), .FIQ_EN(FIQ_EN), .ADDR_W(ADDR_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i[6:0]), .cfg_o(cfg));

  // per-line sensing: level follows input, edge latches a rise
  for (genvar n = 0; n < NUM_SRC; n++) begin : g_sense
    logic rise, clr;
    assign rise = src_i[n] & ~prev_q[n];
    assign clr  = (pend_wr & ~wdata_i[n]) |
                  (irq_hit & (irq_num == IDX_W'(n))) |
                  (fiq_hit & (fiq_num == IDX_W'(n)));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        prev_q[n] <= 1'b0;
        edge_q[n] <= 1'b0;
      end else begin
        prev_q[n] <= src_i[n];
        edge_q[n] <= rise | (edge_q[n] & ~clr);
      end
    end
    assign pend[n] = cfg[n].lvl ? src_i[n] : edge_q[n];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       mask_q <= '1;
    else if (mask_wr) mask_q <= wdata_i[NUM_SRC-1:0];
  end

  assign active = pend & ~mask_q;

  intc_arbiter #(.NUM_SRC(NUM_SRC)) u_arb_irq (
    .clk(clk), .rst_n(rst_n), .active_i(active), .cfg_i(cfg),
    .route_fast_i(1'b0), .found_o(irq_found), .idx_o(irq_idx));
  intc_arbiter #(.NUM_SRC(NUM_SRC)) u_arb_fiq (
    .clk(clk), .rst_n(rst_n), .active_i(active), .cfg_i(cfg),
    .route_fast_i(1'b1), .found_o(fiq_found), .idx_o(fiq_idx));

  intc_route #(.IDX_W(IDX_W)) u_out_irq (
    .clk(clk), .rst_n(rst_n), .found_i(irq_found), .idx_i(irq_idx),
    .ack_i(ctrl_wr & wdata_i[0]), .req_o(irq_o), .num_o(irq_num), .ack_hit_o(irq_hit));
  intc_route #(.IDX_W(IDX_W)) u_out_fiq (
    .clk(clk), .rst_n(rst_n), .found_i(fiq_found), .idx_i(fiq_idx),
    .ack_i(ctrl_wr & wdata_i[1]), .req_o(fiq_o), .num_o(fiq_num), .ack_hit_o(fiq_hit));

  always_comb begin
    rdata_o = '0;
    case (int'(addr_i))
      OFS_PEND: rdata_o = 32'(pend);
      OFS_MASK: rdata_o = 32'(mask_q);
      OFS_IRQN: rdata_o = 32'(irq_num);
      OFS_FIQN: rdata_o = 32'(fiq_num);
      default: begin
        for (int n = 0; n < NUM_SRC; n++)
          if (addr_i == ADDR_W'(cfg_offset(n))) rdata_o = 32'(cfg[n]);
      end
    endcase
  end

  // R4
  masked_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> !(($past(mask_q) >> irq_num) & 1));
  // R6
  edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(edge_q[0]) && !$past(pend_wr) && !$past(irq_hit) && !$past(fiq_hit)) |-> edge_q[0]);

  if (!FIQ_EN) begin : g_sec
    // R3
    sec_no_fast_chk: assert property (@(posedge clk) disable iff (!rst_n) !fiq_o);
  end
endmodule

// File: tb/intc_bank_tb.sv
module intc_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata_a, rdata_b;
  logic        irq_a, fiq_a, irq_b, fiq_b;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  intc_bank #(.NUM_SRC(32), .FIQ_EN(1'b1), .ADDR_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .src_i(src), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata_a), .irq_o(irq_a), .fiq_o(fiq_a));
  intc_bank #(.NUM_SRC(32), .FIQ_EN(1'b0), .ADDR_W(8)) u_dut_sec (
    .clk(clk), .rst_n(rst_n), .src_i(src), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata_b), .irq_o(irq_b), .fiq_o(fiq_b));

  // {lines, expect request, expect number}; urgency of line n is n mod 8
  localparam logic [37:0] VEC [8] = '{
    {32'h0000_0020, 1'b1, 5'd5},
    {32'h0000_0220, 1'b1, 5'd9},
    {32'h0001_0100, 1'b1, 5'd8},
    {32'hC000_0000, 1'b1, 5'd30},
    {32'h0000_0000, 1'b0, 5'd0},
    {32'h0100_8002, 1'b1, 5'd24},
    {32'hFFFF_FFFF, 1'b1, 5'd0},
    {32'h0004_0404, 1'b1, 5'd2}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] da, output logic [31:0] db);
    addr = a;
    #1;
    da = rdata_a; db = rdata_b;
  endtask

  task automatic idle(input int c);
    repeat (c) @(negedge clk);
  endtask

  initial begin
    logic [31:0] ra, rb;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    rd(8'h04, ra, rb); chk("R1 mask", ra, 32'hFFFF_FFFF);
    rd(8'h10, ra, rb); chk("R1 irq num", ra, 0);
    rd(8'h14, ra, rb); chk("R1 fiq num", ra, 0);
    rd(8'h3C, ra, rb); chk("R1 cfg word", ra, 0);
    chk("R1 requests", {30'd0, irq_a, fiq_a}, 0);

    // R2 layout and unused bits
    wr(8'h54, 32'hFFFF_FFFF);
    rd(8'h54, ra, rb); chk("R2 readback", ra, 32'h7F);
    chk("R3 secondary fast bit", rb, 32'h7E);

    for (int n = 0; n < 32; n++) wr(8'(32 + 4 * n), ((n % 8) << 2) | 2);
    wr(8'h04, 0);

    // R7 R8 arbitration table
    for (int v = 0; v < 8; v++) begin
      src = VEC[v][37:6];
      idle(3);
      chk("R8 irq request", {31'd0, irq_a}, {31'd0, VEC[v][5]});
      rd(8'h10, ra, rb); chk("R7 winner", ra, {27'd0, VEC[v][4:0]});
      src = '0;
      wr(8'h18, 1);
      idle(2);
    end

    // R3 fast-routed line on both banks
    wr(8'h30, 32'h7F);
    src = 32'h10;
    idle(3);
    chk("R3 primary fast", {30'd0, fiq_a, irq_a}, 32'h2);
    chk("R3 secondary normal", {30'd0, fiq_b, irq_b}, 32'h1);
    rd(8'h10, ra, rb); chk("R3 secondary num", rb, 4);
    src = '0;
    wr(8'h30, (4 << 2) | 2);
    wr(8'h18, 3);
    idle(2);

    // R4 R5 mask and level pending
    wr(8'h04, 32'h20);
    src = 32'h20;
    idle(3);
    chk("R4 masked request", {31'd0, irq_a}, 0);
    rd(8'h00, ra, rb); chk("R4 pending visible", ra, 32'h20);
    src = '0;
    idle(1);
    rd(8'h00, ra, rb); chk("R5 level follows", ra, 0);

    // R6 edge latch, write clear, acknowledge clear
    wr(8'h50, 0);
    wr(8'h04, 32'h1000);
    src = 32'h1000; idle(1); src = '0;
    idle(2);
    rd(8'h00, ra, rb); chk("R6 latched", ra, 32'h1000);
    wr(8'h00, 32'hFFFF_EFFF);
    rd(8'h00, ra, rb); chk("R6 write clear", ra, 0);
    wr(8'h04, 0);
    src = 32'h1000; idle(1); src = '0;
    idle(3);
    rd(8'h10, ra, rb); chk("R6 edge request", {irq_a, ra[30:0]}, 32'h8000_000C);
    wr(8'h18, 1);
    idle(2);
    rd(8'h00, ra, rb); chk("R6 ack clear", {irq_a, ra[30:0]}, 0);
    wr(8'h50, (4 << 2) | 2);

    // R9 R10 both requests, freeze and separate acknowledges
    wr(8'h38, (6 << 2) | 3);
    src = 32'h48;
    idle(3);
    rd(8'h14, ra, rb); chk("R9 fast num", {fiq_a, ra[30:0]}, 32'h8000_0006);
    rd(8'h10, ra, rb); chk("R9 normal num", {irq_a, ra[30:0]}, 32'h8000_0003);
    src = 32'h4A;
    idle(3);
    rd(8'h10, ra, rb); chk("R10 frozen", ra, 3);
    wr(8'h18, 2);
    idle(3);
    rd(8'h10, ra, rb); chk("R10 fast ack spares normal", ra, 3);
    rd(8'h14, ra, rb); chk("R10 fast re-decided", {fiq_a, ra[30:0]}, 32'h8000_0006);
    wr(8'h18, 1);
    idle(3);
    rd(8'h10, ra, rb); chk("R10 new normal winner", ra, 1);
    src = '0;
    wr(8'h18, 3);
    idle(3);
    rd(8'h10, ra, rb); chk("R10 both cleared irq", {irq_a, ra[30:0]}, 0);
    rd(8'h14, ra, rb); chk("R10 both cleared fiq", {fiq_a, ra[30:0]}, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule